// File: doc/BRIEF.md
# Line Timer with Group Pattern Alternation

This block counts pixel clocks across each horizontal line and gives a one-cycle pulse on the last pixel of the line. Even and odd lines each have their own programmable length, so the line period can alternate from one line to the next. A parity flag records which kind of line is running. The first line after a field start is always even.

Every line end also steps four pattern groups, numbered 0 to 3 (A to D). Each group holds a pattern index, and a repetition mode sampled at field start sets how the index moves. In the simplest mode the index stays at 0. Other modes alternate the index between two values, cycle group 0 through three or four values, or run groups 1 to 3 through the fixed cycle 0,1,1. Each of the outputs is assigned to one group through a 2-bit code. Each output reports the current index of its group and that group's starting-polarity bit for the output. A later stage that builds the vertical clock waveforms uses these values.

Top module: `line_alt_timer`

## Requirements
- R1: With wide mode off, `line_end` pulses once every L clocks. L is `len_even` on even lines and `len_odd` on odd lines. The first pulse after field start comes L clocks after the field start cycle. After each pulse the counter returns to 0.
- R2: When `wide_en` is 1, `len_even_top` and `len_odd_top` form the extra most significant length bit (bit LEN_W). When `wide_en` is 0, these two inputs have no effect on the line length.
- R3: An effective length of 0 or 1 gives a line of 2 clocks.
- R4: `line_odd` is 0 on the first line after field start and inverts on every `line_end` pulse.
- R5: After reset, and in the cycle after `field_start` is high, the counter is 0, `line_odd` is 0 and every group index is 0. `line_end` stays low while `field_start` is high.
- R6: In mode 2'b00 every group index stays at 0.
- R7: In mode 2'b01 every group index follows 0,1,0,1 across line ends.
- R8: In mode 2'b10 group 0 follows 0,1,2,0,1,2 and groups 1 to 3 follow 0,1,1,0,1,1.
- R9: In mode 2'b11 group 0 follows 0,1,2,3 repeating and groups 1 to 3 follow 0,1,0,1.
- R10: `rep_mode` is sampled only on `field_start`. A change during a field does not alter the index sequences of that field. The mode after reset is 2'b00.
- R11: `grp_idx[2g+1:2g]` is the index of group g. Output i (0-based) takes its group code from `{grp_map_hi,grp_map_lo}[2i+1:2i]`, where code 0..3 selects group 0..3. Outputs 0 to 11 therefore use `grp_map_lo` and outputs 12 to 23 use `grp_map_hi`. `out_idx[2i+1:2i]` equals the index of the group assigned to output i.
- R12: `out_pol[i]` equals bit i of `pol_a`, `pol_b`, `pol_c` or `pol_d` for group code 0, 1, 2 or 3 of output i.
- R13: Group indices change only at clock edges where `line_end` or `field_start` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| field_start | input | 1 | Synchronous restart of counter, parity and indices; samples mode |
| wide_en | input | 1 | Enables the extra length bit |
| len_even | input | LEN_W | Even-line length |
| len_even_top | input | 1 | Extra length bit for even lines |
| len_odd | input | LEN_W | Odd-line length |
| len_odd_top | input | 1 | Extra length bit for odd lines |
| rep_mode | input | 2 | Repetition mode |
| grp_map_lo | input | NUM_OUT | Group codes of outputs 0 to NUM_OUT/2-1 |
| grp_map_hi | input | NUM_OUT | Group codes of outputs NUM_OUT/2 to NUM_OUT-1 |
| pol_a | input | NUM_OUT | Starting polarities, group 0 |
| pol_b | input | NUM_OUT | Starting polarities, group 1 |
| pol_c | input | NUM_OUT | Starting polarities, group 2 |
| pol_d | input | NUM_OUT | Starting polarities, group 3 |
| line_end | output | 1 | One-cycle pulse on the last count of a line |
| line_odd | output | 1 | 1 while an odd line runs |
| grp_idx | output | 8 | Pattern index of each group, two bits each |
| out_idx | output | 2*NUM_OUT | Pattern index seen by each output |
| out_pol | output | NUM_OUT | Starting polarity seen by each output |

## Verification
The bench builds the block with LEN_W = 5 and keeps the default 24 outputs. The narrow length field makes it possible to sweep every even/odd length pair, including the clamped values 0 and 1. With the extra bit, the longest line, 63 clocks, is also within reach. Each of these fields uses a different repetition mode and different group maps. Longer fields in every mode run past the least common multiple of the sequence periods, with `rep_mode` changed in the middle of the field. The extra length bit is tried both enabled and disabled.

// File: rtl/line_alt_timer.sv
module line_alt_timer #(
  parameter int LEN_W   = 13,
  parameter int NUM_OUT = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 field_start,
  input  logic                 wide_en,
  input  logic [LEN_W-1:0]     len_even,
  input  logic                 len_even_top,
  input  logic [LEN_W-1:0]     len_odd,
  input  logic                 len_odd_top,
  input  logic [1:0]           rep_mode,
  input  logic [NUM_OUT-1:0]   grp_map_lo,
  input  logic [NUM_OUT-1:0]   grp_map_hi,
  input  logic [NUM_OUT-1:0]   pol_a,
  input  logic [NUM_OUT-1:0]   pol_b,
  input  logic [NUM_OUT-1:0]   pol_c,
  input  logic [NUM_OUT-1:0]   pol_d,
  output logic                 line_end,
  output logic                 line_odd,
  output logic [7:0]           grp_idx,
  output logic [2*NUM_OUT-1:0] out_idx,
  output logic [NUM_OUT-1:0]   out_pol
);
  localparam int CW = LEN_W + 1;
  localparam int NG = 4;

  logic [CW-1:0] cnt, len_sel, last;
  logic [1:0]    mode_q;
  logic          at_last;

  assign len_sel  = line_odd ? {wide_en & len_odd_top, len_odd}
                             : {wide_en & len_even_top, len_even};
  assign last     = (len_sel < CW'(2)) ? CW'(1) : len_sel - CW'(1);
  assign at_last  = (cnt >= last);
  assign line_end = at_last & ~field_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      line_odd <= 1'b0;
      mode_q   <= 2'b00;
    end else if (field_start) begin
      cnt      <= '0;
      line_odd <= 1'b0;
      mode_q   <= rep_mode;
    end else if (at_last) begin
      cnt      <= '0;
      line_odd <= ~line_odd;
    end else begin
      cnt      <= cnt + CW'(1);
    end
  end

  logic [1:0] ph [NG];

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [1:0] top;
    always_comb begin
      case (mode_q)
        2'b00:   top = 2'd0;
        2'b01:   top = 2'd1;
        2'b10:   top = 2'd2;
        default: top = (g == 0) ? 2'd3 : 2'd1;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ph[g] <= 2'd0;
      else if (field_start) ph[g] <= 2'd0;
      else if (line_end)    ph[g] <= (ph[g] >= top) ? 2'd0 : ph[g] + 2'd1;
    end

    assign grp_idx[2*g +: 2] = (g != 0 && mode_q == 2'b10) ? {1'b0, ph[g] != 2'd0} : ph[g];
  end

  logic [2*NUM_OUT-1:0] map_all;
  assign map_all = {grp_map_hi, grp_map_lo};

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    logic [1:0] code;
    logic [3:0] pv;
    assign code             = map_all[2*i +: 2];
    assign pv               = {pol_d[i], pol_c[i], pol_b[i], pol_a[i]};
    assign out_idx[2*i +: 2] = grp_idx[2*code +: 2];
    assign out_pol[i]        = pv[code];
  end

  p_wrap_after_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> cnt == '0);

  p_parity_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> line_odd != $past(line_odd));

  p_field_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> (cnt == '0 && !line_odd && grp_idx == 8'd0));

  p_single_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b00 |-> grp_idx == 8'd0);

  p_three_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q == 2'b10 |-> grp_idx[1:0] != 2'd3);

  p_mode_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(mode_q));

  p_idx_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_end && !field_start) |=> $stable(grp_idx));
endmodule

// File: tb/line_alt_timer_bench.sv
`timescale 1ns/1ps
module line_alt_timer_bench;
  localparam int LW = 5;
  localparam int NO = 24;

  logic clk = 1'b0, rst_n = 1'b0, field_start = 1'b0, wide_en = 1'b0;
  logic [LW-1:0] len_even = 5, len_odd = 5;
  logic len_even_top = 1'b0, len_odd_top = 1'b0;
  logic [1:0] rep_mode = 2'b00;
  logic [NO-1:0] grp_map_lo = '0, grp_map_hi = '0;
  logic [NO-1:0] pol_a = 24'h5A3C96, pol_b = 24'hC3A50F, pol_c = 24'h0FF00F, pol_d = 24'h936CA5;
  logic line_end, line_odd;
  logic [7:0] grp_idx;
  logic [2*NO-1:0] out_idx;
  logic [NO-1:0] out_pol;

  int checks = 0, fails = 0;

  line_alt_timer #(.LEN_W(LW), .NUM_OUT(NO)) u_line_alt_timer (
    .clk, .rst_n, .field_start, .wide_en, .len_even, .len_even_top, .len_odd,
    .len_odd_top, .rep_mode, .grp_map_lo, .grp_map_hi, .pol_a, .pol_b, .pol_c,
    .pol_d, .line_end, .line_odd, .grp_idx, .out_idx, .out_pol);

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_grp(input logic [1:0] m, input int k);
    logic [7:0] r;
    r = '0;
    for (int g = 0; g < 4; g++) begin
      int v;
      case (m)
        2'b00: v = 0;
        2'b01: v = k % 2;
        2'b10: v = (g == 0) ? k % 3 : ((k % 3) != 0 ? 1 : 0);
        default: v = (g == 0) ? k % 4 : k % 2;
      endcase
      r[2*g +: 2] = 2'(v);
    end
    return r;
  endfunction

  function automatic int eff_len(input int l, input bit t, input bit w);
    int e;
    e = l + ((t && w) ? (1 << LW) : 0);
    return (e < 2) ? 2 : e;
  endfunction

  task automatic check_outputs(input logic [7:0] eg, input string mtag);
    logic [2*NO-1:0] ei;
    logic [NO-1:0] ep;
    logic [2*NO-1:0] m;
    m = {grp_map_hi, grp_map_lo};
    for (int i = 0; i < NO; i++) begin
      int c;
      c = int'(m[2*i +: 2]);
      ei[2*i +: 2] = eg[2*c +: 2];
      case (c)
        0: ep[i] = pol_a[i];
        1: ep[i] = pol_b[i];
        2: ep[i] = pol_c[i];
        default: ep[i] = pol_d[i];
      endcase
    end
    check(grp_idx == eg, {mtag, "/R10 group index"}, 64'(grp_idx), 64'(eg));
    check(out_idx == ei, "R11 output index map", 64'(out_idx), 64'(ei));
    check(out_pol == ep, "R12 output polarity map", 64'(out_pol), 64'(ep));
  endtask

  task automatic run_field(input int le, input int lo, input bit te, input bit to,
                           input bit w, input logic [1:0] m,
                           input logic [NO-1:0] mlo, input logic [NO-1:0] mhi, input int nl);
    string mtag;
    case (m)
      2'b00: mtag = "R6";
      2'b01: mtag = "R7";
      2'b10: mtag = "R8";
      default: mtag = "R9";
    endcase
    @(negedge clk);
    len_even = LW'(le); len_odd = LW'(lo); len_even_top = te; len_odd_top = to;
    wide_en = w; rep_mode = m; grp_map_lo = mlo; grp_map_hi = mhi;
    field_start = 1'b1;
    #1;
    check(line_end == 1'b0, "R5 no pulse during field start", 64'(line_end), 64'd0);
    @(negedge clk);
    field_start = 1'b0;
    rep_mode = ~m;
    check(line_odd == 1'b0 && grp_idx == 8'd0, "R5 field start clear",
          64'({line_odd, grp_idx}), 64'd0);
    for (int k = 0; k < nl; k++) begin
      int n, el;
      bit held;
      string ltag;
      logic [7:0] cur;
      bit odd;
      odd = (k % 2) == 1;
      el = odd ? eff_len(lo, to, w) : eff_len(le, te, w);
      if ((odd ? lo : le) < 2 && !(w && (odd ? to : te))) ltag = "R3 clamped length";
      else if (odd ? to : te) ltag = "R2 extra length bit";
      else ltag = "R1 line length";
      cur = exp_grp(m, k);
      held = 1'b1;
      n = 1;
      while (!line_end && n < 200) begin
        @(negedge clk);
        n++;
        if (grp_idx != cur) held = 1'b0;
      end
      check(n == el, ltag, 64'(n), 64'(el));
      check(held, "R13 index held within line", 64'(held), 64'd1);
      @(negedge clk);
      check(line_odd == ((k + 1) % 2 == 1), "R4 line parity", 64'(line_odd), 64'((k + 1) % 2));
      check_outputs(exp_grp(m, k + 1), mtag);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(line_odd == 1'b0 && grp_idx == 8'd0 && line_end == 1'b0, "R5 reset state",
          64'({line_end, line_odd, grp_idx}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(grp_idx == 8'd0 && line_odd == 1'b0, "R5 state after reset release",
          64'({line_odd, grp_idx}), 64'd0);

    for (int le = 0; le < 32; le++)
      for (int lo = 0; lo < 32; lo++)
        run_field(le, lo, 1'b0, 1'b0, 1'b0, 2'((le + lo) % 4),
                  NO'(le * 32'h9E3779 + lo * 32'h51ED27), NO'(lo * 32'h2545F4 + le * 32'h7F4A7C), 2);

    run_field(3, 6, 1'b1, 1'b1, 1'b0, 2'b01, 24'hE4E4E4, 24'h1B1B1B, 4);
    run_field(3, 6, 1'b1, 1'b1, 1'b1, 2'b01, 24'hE4E4E4, 24'h1B1B1B, 4);
    run_field(31, 0, 1'b1, 1'b1, 1'b1, 2'b11, 24'hFFFFFF, 24'h000000, 4);
    run_field(0, 1, 1'b0, 1'b0, 1'b1, 2'b10, 24'h555555, 24'hAAAAAA, 4);

    for (int m = 0; m < 4; m++) begin
      pol_a = pol_a ^ 24'h0F0F0F;
      pol_c = ~pol_c;
      run_field(2, 3, 1'b0, 1'b0, 1'b0, 2'(m), 24'hE4E4E4, 24'h39C6E4, 13);
      run_field(4, 2, 1'b0, 1'b0, 1'b0, 2'(m), 24'h1B6C93, 24'hFFAA55, 13);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule